// File: doc/BRIEF.md
# DMA Channel Address and Count Register File

This block holds the programming state of four DMA channels: a 16-bit starting address and a 16-bit transfer length per channel. Both are loaded over an 8-bit I/O port one byte at a time. A single byte-pointer toggle, shared by every port, decides whether an access hits the low or the high byte. Writing a high byte arms the channel: the working address is reloaded from the programmed address and the count of bytes moved is cleared.

While a channel transfers, its data mover pulses an advance strobe with the number of bytes just moved. The block accumulates that count, and it stops the count at the programmed length. Software reads back progress through the same ports. An address read returns the live transfer address, and a count read returns the remaining count. Both values are derived on the fly from the programmed values and the accumulated count.

The parameter `WIDTH_SHIFT` selects the 8-bit variant (0) or the 16-bit variant (1). In the 16-bit variant, ports sit on every other address, addresses and counts are kept in byte units scaled by two, and readback is scaled back down.

Top module: `dma_chan_regs`

## Requirements
- R1: The port offset is `io_addr_i[WIDTH_SHIFT+2:WIDTH_SHIFT]`, and lower address bits are ignored. Offset bit 0 selects the address register (0) or the count register (1). Offset bits 2:1 give the channel number.
- R2: One byte toggle serves every channel and both registers. It is 0 after reset. A value of 0 selects the low byte and 1 selects the high byte. The toggle inverts at the end of every port read or write.
- R3: A low-byte write replaces bits 7:0 of the selected programmed register and leaves bits 15:8 unchanged. A high-byte write replaces bits 15:8 and leaves bits 7:0 unchanged.
- R4: A high-byte write to either register of a channel sets that channel's working address to its programmed address shifted left by `WIDTH_SHIFT`, and clears its moved count to 0. A low-byte write changes neither.
- R5: Address readback is computed as follows. Take the working address, add the moved count (or subtract it when the channel's `chan_dec_i` bit is 1), and keep the result modulo 2^(16+WIDTH_SHIFT). Shift it right by `WIDTH_SHIFT`. Return the low byte when the toggle is 0 and the high byte when it is 1.
- R6: Count readback is computed as follows. Take the programmed count shifted left by `WIDTH_SHIFT`, subtract the moved count, and keep the result modulo 2^(16+WIDTH_SHIFT). Shift it right by `WIDTH_SHIFT` and select a byte by the toggle, as in R5.
- R7: A pulse on `adv_i[c]` adds `adv_amt_i[c*AMT_W +: AMT_W]` to channel c's moved count. The result is limited to (programmed count + 1) << `WIDTH_SHIFT`.
- R8: `ff_clear_i` and `master_reset_i` each force the toggle to 0 at the next edge. This takes priority over an access in the same cycle.
- R9: After reset, every programmed register, working address and moved count is 0, so every readback byte is 0.
- R10: When a high-byte write and an advance hit the same channel in the same cycle, the reload wins and the moved count becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | 3+WIDTH_SHIFT | Port address |
| io_wr_i | input | 1 | Port write strobe |
| io_rd_i | input | 1 | Port read strobe |
| io_wdata_i | input | 8 | Write byte |
| io_rdata_o | output | 8 | Readback byte, valid while io_rd_i is high |
| ff_clear_i | input | 1 | Clear-toggle strobe |
| master_reset_i | input | 1 | Controller reset strobe (clears toggle) |
| chan_dec_i | input | NUM_CH | Per-channel address decrement flag |
| adv_i | input | NUM_CH | Per-channel progress strobe |
| adv_amt_i | input | NUM_CH*AMT_W | Per-channel byte amount for adv_i |

## Verification
A toggle that falls out of step is the most damaging internal fault. Every later byte then lands in the wrong half, so the first two-byte readback after the slip already shows swapped or mixed bytes. A wrong working address or moved count shows up on the very next address or count read of that channel, because readback is recomputed every cycle. A saturation fault appears only once a channel's advances pass its programmed length. For that reason, the advance sweeps drive every channel beyond its length and read back after each step.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  typedef enum logic {
    REG_ADDR = 1'b0,
    REG_CNT  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/dma_port_decode.sv
module dma_port_decode
  import dma_regs_pkg::*;
#(
  parameter int WIDTH_SHIFT = 0,
  parameter int CH_W        = 2,
  localparam int PORT_AW    = WIDTH_SHIFT + 1 + CH_W
) (
  input  logic [PORT_AW-1:0] addr_i,
  input  logic               wr_i,
  input  logic               rd_i,
  output logic [CH_W-1:0]    chan_o,
  output reg_sel_e           sel_o,
  output logic               acc_o,
  output logic               wr_o
);
  logic [CH_W:0] idx;

  assign idx    = addr_i[PORT_AW-1:WIDTH_SHIFT];
  assign sel_o  = reg_sel_e'(idx[0]);
  assign chan_o = idx[CH_W:1];
  // a write wins when both strobes are set; the toggle still flips once
  assign wr_o   = wr_i;
  assign acc_o  = wr_i | rd_i;
endmodule

// File: rtl/dma_byte_toggle.sv
module dma_byte_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic acc_i,
  input  logic clr_i,
  output logic hi_o
);
  logic ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ff_q <= 1'b0;
    else if (clr_i) ff_q <= 1'b0;
    else if (acc_i) ff_q <= ~ff_q;
  end

  assign hi_o = ff_q;

  // R2
  toggle_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && !clr_i |=> hi_o != $past(hi_o));
  // R8
  toggle_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !hi_o);
  // R2
  toggle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_i && !clr_i |=> $stable(hi_o));
endmodule

// File: rtl/dma_chan_slot.sv
module dma_chan_slot
  import dma_regs_pkg::*;
#(
  parameter int WIDTH_SHIFT = 0,
  parameter int AMT_W       = 8,
  localparam int CUR_W      = 16 + WIDTH_SHIFT,
  localparam int XFR_W      = 17 + WIDTH_SHIFT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  reg_sel_e         sel_i,
  input  logic [7:0]       wdata_i,
  input  logic             dec_i,
  input  logic             adv_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic [15:0]      rb_addr_o,
  output logic [15:0]      rb_cnt_o
);
  logic [15:0]      base_addr_q, base_cnt_q, reload_src;
  logic [CUR_W-1:0] cur_q, addr_live, cnt_live;
  logic [XFR_W-1:0] xfer_q, len, xfer_nxt;
  logic [XFR_W:0]   sum;

  assign len = (XFR_W'({1'b0, base_cnt_q} + 17'd1)) << WIDTH_SHIFT;
  assign sum = {1'b0, xfer_q} + {{(XFR_W + 1 - AMT_W){1'b0}}, amt_i};
  assign xfer_nxt = (sum >= {1'b0, len}) ? len : sum[XFR_W-1:0];
  assign reload_src = (sel_i == REG_ADDR) ? {wdata_i, base_addr_q[7:0]} : base_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
    end else if (wr_lo_i) begin
      if (sel_i == REG_ADDR) base_addr_q[7:0] <= wdata_i;
      else                   base_cnt_q[7:0]  <= wdata_i;
    end else if (wr_hi_i) begin
      if (sel_i == REG_ADDR) base_addr_q[15:8] <= wdata_i;
      else                   base_cnt_q[15:8]  <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      xfer_q <= '0;
    end else if (wr_hi_i) begin
      cur_q  <= CUR_W'(reload_src) << WIDTH_SHIFT;
      xfer_q <= '0;
    end else if (adv_i) begin
      xfer_q <= xfer_nxt;
    end
  end

  assign addr_live = dec_i ? (cur_q - CUR_W'(xfer_q)) : (cur_q + CUR_W'(xfer_q));
  assign cnt_live  = (CUR_W'(base_cnt_q) << WIDTH_SHIFT) - CUR_W'(xfer_q);
  assign rb_addr_o = addr_live[CUR_W-1:WIDTH_SHIFT];
  assign rb_cnt_o  = cnt_live[CUR_W-1:WIDTH_SHIFT];

  // R4
  reload_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_i |=> xfer_q == '0);
  // R4
  reload_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_i && sel_i == REG_ADDR |=> rb_addr_o[15:8] == $past(wdata_i));
  // R3
  lo_keeps_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i && sel_i == REG_ADDR |=> base_addr_q[15:8] == $past(base_addr_q[15:8]));
  // R7
  adv_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !wr_hi_i |=> (xfer_q >= $past(xfer_q)) || (xfer_q == $past(len)));
  // R7
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i && !wr_hi_i |=> $stable(xfer_q));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
#(
  parameter int WIDTH_SHIFT = 0,
  parameter int NUM_CH      = 4,
  parameter int AMT_W       = 8,
  localparam int CH_W       = $clog2(NUM_CH),
  localparam int PORT_AW    = WIDTH_SHIFT + 1 + CH_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [PORT_AW-1:0]      io_addr_i,
  input  logic                    io_wr_i,
  input  logic                    io_rd_i,
  input  logic [7:0]              io_wdata_i,
  output logic [7:0]              io_rdata_o,
  input  logic                    ff_clear_i,
  input  logic                    master_reset_i,
  input  logic [NUM_CH-1:0]       chan_dec_i,
  input  logic [NUM_CH-1:0]       adv_i,
  input  logic [NUM_CH*AMT_W-1:0] adv_amt_i
);
  logic [CH_W-1:0] chan;
  reg_sel_e        sel;
  logic            acc, wr, hi;
  logic [15:0]     rb_addr [NUM_CH];
  logic [15:0]     rb_cnt  [NUM_CH];
  logic [15:0]     rb_sel;

  dma_port_decode #(.WIDTH_SHIFT(WIDTH_SHIFT), .CH_W(CH_W)) u_decode (
    .addr_i (io_addr_i),
    .wr_i   (io_wr_i),
    .rd_i   (io_rd_i),
    .chan_o (chan),
    .sel_o  (sel),
    .acc_o  (acc),
    .wr_o   (wr)
  );

  dma_byte_toggle u_toggle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .acc_i  (acc),
    .clr_i  (ff_clear_i | master_reset_i),
    .hi_o   (hi)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic hit;
    assign hit = wr && (chan == CH_W'(g));
    dma_chan_slot #(.WIDTH_SHIFT(WIDTH_SHIFT), .AMT_W(AMT_W)) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_lo_i   (hit && !hi),
      .wr_hi_i   (hit && hi),
      .sel_i     (sel),
      .wdata_i   (io_wdata_i),
      .dec_i     (chan_dec_i[g]),
      .adv_i     (adv_i[g]),
      .amt_i     (adv_amt_i[g*AMT_W +: AMT_W]),
      .rb_addr_o (rb_addr[g]),
      .rb_cnt_o  (rb_cnt[g])
    );
  end

  assign rb_sel     = (sel == REG_CNT) ? rb_cnt[chan] : rb_addr[chan];
  assign io_rdata_o = hi ? rb_sel[15:8] : rb_sel[7:0];
endmodule

// File: tb/dma_chan_regs_tb_top.sv
`timescale 1ns/1ps
module dma_chan_regs_tb_top;
  localparam int S  = 1;
  localparam int NC = 4;
  localparam int AW = 8;
  localparam int CW = 16 + S;
  localparam int XW = 17 + S;
  localparam int PA = S + 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [PA-1:0] io_addr = '0;
  logic io_wr = 1'b0, io_rd = 1'b0, ff_clr = 1'b0, mrst = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic [NC-1:0] dec_v = '0, adv = '0;
  logic [NC*AW-1:0] amt = '0;

  int checks = 0, fails = 0;
  bit done = 1'b0, junk = 1'b0;

  logic [15:0]   m_ba [NC];
  logic [15:0]   m_bc [NC];
  logic [CW-1:0] m_cur[NC];
  logic [XW-1:0] m_xf [NC];
  bit            m_tog;

  always #2.5 clk = ~clk;

  dma_chan_regs #(.WIDTH_SHIFT(S), .NUM_CH(NC), .AMT_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(io_addr), .io_wr_i(io_wr),
    .io_rd_i(io_rd), .io_wdata_i(wdata), .io_rdata_o(rdata),
    .ff_clear_i(ff_clr), .master_reset_i(mrst), .chan_dec_i(dec_v),
    .adv_i(adv), .adv_amt_i(amt)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(int ch, int r);
    logic [CW-1:0] v;
    logic [15:0] r16;
    if (r != 0) v = (CW'(m_bc[ch]) << S) - CW'(m_xf[ch]);
    else if (dec_v[ch]) v = m_cur[ch] - CW'(m_xf[ch]);
    else v = m_cur[ch] + CW'(m_xf[ch]);
    r16 = v[CW-1:S];
    return m_tog ? r16[15:8] : r16[7:0];
  endfunction

  // R1: junk drives the ignored low address bit
  function automatic logic [PA-1:0] port(int ch, int r);
    return {ch[1:0], r[0], junk};
  endfunction

  task automatic do_wr(int ch, int r, logic [7:0] d);
    @(negedge clk);
    junk = ~junk;
    io_addr = port(ch, r); wdata = d; io_wr = 1'b1;
    @(posedge clk);
    if (!m_tog) begin
      if (r != 0) m_bc[ch][7:0] = d; else m_ba[ch][7:0] = d;
    end else begin
      if (r != 0) m_bc[ch][15:8] = d; else m_ba[ch][15:8] = d;
      m_cur[ch] = CW'(m_ba[ch]) << S;
      m_xf[ch] = '0;
    end
    m_tog = !m_tog;
    #1 io_wr = 1'b0;
  endtask

  task automatic do_rd(int ch, int r, string req);
    @(negedge clk);
    junk = ~junk;
    io_addr = port(ch, r); io_rd = 1'b1;
    #1 check(req, rdata, exp_byte(ch, r));
    @(posedge clk);
    m_tog = !m_tog;
    #1 io_rd = 1'b0;
  endtask

  task automatic clr_tog();
    @(negedge clk); ff_clr = 1'b1;
    @(posedge clk); m_tog = 1'b0;
    #1 ff_clr = 1'b0;
  endtask

  task automatic do_adv(logic [NC-1:0] m, logic [NC*AW-1:0] a);
    logic [XW:0] sum;
    logic [XW-1:0] len;
    @(negedge clk); adv = m; amt = a;
    @(posedge clk);
    for (int c = 0; c < NC; c++) if (m[c]) begin
      len = XW'({1'b0, m_bc[c]} + 17'd1) << S;
      sum = {1'b0, m_xf[c]} + (XW+1)'(a[c*AW +: AW]);
      m_xf[c] = (sum >= {1'b0, len}) ? len : sum[XW-1:0];
    end
    #1 adv = '0;
  endtask

  task automatic rd_all(string req);
    for (int c = 0; c < NC; c++) begin
      do_rd(c, 0, req); do_rd(c, 0, req);
      do_rd(c, 1, req); do_rd(c, 1, req);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NC; c++) begin
      m_ba[c] = '0; m_bc[c] = '0; m_cur[c] = '0; m_xf[c] = '0;
    end
    m_tog = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R9 reset state, R2 toggle walk
    rd_all("R9");

    // R1 R3 R4 R5 R6 sweep: program every channel with several patterns
    for (int k = 0; k < 4; k++) begin
      for (int c = 0; c < NC; c++) begin
        clr_tog();
        do_wr(c, 0, 8'(8'h11 * (c + 1) + k * 8'h35));
        do_wr(c, 0, 8'(8'hA0 ^ (c << 4) ^ k));
        do_wr(c, 1, 8'(8'h07 + c + k * 3));
        do_wr(c, 1, 8'(k * 8'h41 + c));
      end
      dec_v = 4'(k * 5);
      clr_tog();
      rd_all("R5 R6 sweep");
    end

    // R3/R4: low write alone keeps upper byte and does not reload
    clr_tog();
    do_wr(2, 0, 8'h34); do_wr(2, 0, 8'h12);
    clr_tog();
    do_wr(2, 0, 8'hCD);
    clr_tog();
    do_rd(2, 0, "R4 no reload lo"); do_rd(2, 0, "R4 no reload hi");
    clr_tog();
    do_rd(2, 0, "R3"); // toggle to 1
    do_wr(2, 0, 8'h56);
    clr_tog();
    do_rd(2, 0, "R3 lo kept"); do_rd(2, 0, "R3 hi new");
    check("R3 base", {16'h0, m_ba[2]}, 32'h56CD);

    // R7: advance sweep past saturation with mixed directions
    dec_v = 4'b1010;
    for (int c = 0; c < NC; c++) begin
      clr_tog();
      do_wr(c, 1, 8'(8'h08 + c)); do_wr(c, 1, 8'h00);
      clr_tog();
      do_wr(c, 0, 8'(8'h80 + c)); do_wr(c, 0, 8'h40);
    end
    for (int st = 0; st < 12; st++) begin
      do_adv(4'(st | 1), {8'(st + 1), 8'(3 * st), 8'd5, 8'(2 * st + 1)});
      clr_tog();
      rd_all("R7");
    end
    check("R7 sat", 32'(m_xf[0]), 32'((16'h08 + 1) << S));

    // R10: reload beats advance in the same cycle
    clr_tog();
    do_rd(1, 1, "R10");
    @(negedge clk);
    io_addr = port(1, 1); wdata = 8'h02; io_wr = 1'b1; adv = 4'b0010; amt = {NC{8'd9}};
    @(posedge clk);
    m_bc[1][15:8] = 8'h02; m_cur[1] = CW'(m_ba[1]) << S; m_xf[1] = '0; m_tog = 1'b0;
    #1 io_wr = 1'b0; adv = '0;
    do_rd(1, 1, "R10 cnt lo"); do_rd(1, 1, "R10 cnt hi");
    do_rd(1, 0, "R10 addr lo"); do_rd(1, 0, "R10 addr hi");

    // R8: master reset and clear both win over a same-cycle access
    for (int v = 0; v < 2; v++) begin
      clr_tog();
      do_rd(3, 0, "R8");
      @(negedge clk);
      io_addr = port(3, 1); io_rd = 1'b1;
      if (v == 0) mrst = 1'b1; else ff_clr = 1'b1;
      #1 check("R8 hi before clear", rdata, exp_byte(3, 1));
      @(posedge clk); m_tog = 1'b0;
      #1 io_rd = 1'b0; mrst = 1'b0; ff_clr = 1'b0;
      do_rd(3, 1, "R8 lo after clear");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule